// File: doc/BRIEF.md
# SPI Byte FIFO and Interrupt Status Unit

This unit sits between a host register interface and the shift engine of an SPI controller. It holds one byte queue for outgoing data and one for incoming data. The host fills the outgoing queue through a byte write port and empties the incoming queue through a byte read port. The shift engine pops outgoing bytes and pushes received bytes through its own pair of ports. Each queue has a programmable threshold, and each threshold drives a level-sensitive request.

Four interrupt sources are held as sticky status bits, and each is cleared by writing 1 to it: receive threshold reached, transmit threshold reached, receive overflow, and transfer complete. The interrupt line is the OR of every status bit that is also enabled. A queue flush goes through a two-state sequencer with the states `FL_IDLE` and `FL_FLUSH`. Writing a flush bit moves the sequencer from `FL_IDLE` to `FL_FLUSH`. `FL_FLUSH` always returns to `FL_IDLE` on the next cycle and empties the queue as it leaves.

The register word address selects one of four registers: 0 interrupt enable, 1 interrupt status, 2 queue control, 3 queue level. The same bit positions are used in the enable and status words: bit 0 receive-ready, bit 4 transmit-request, bit 8 receive-overflow, bit 12 transfer-complete. All other bits read as 0.

Top module: `spi_fifo_irq`

## Requirements
- R1: After reset both queue levels are 0. The level word (address 3) reports the receive count in bits 7:0 and the transmit count from bit 16 upward.
- R2: Bytes written on the host write port leave on `eng_tx_data` in the same order. `eng_tx_data` shows the oldest byte before it is popped. A write to a full transmit queue is dropped, and the count stays at DEPTH.
- R3: Bytes pushed by the engine are read back on `rx_rd_data` in the same order. A read on an empty receive queue leaves the count at 0.
- R4: Status bit 0 is set one cycle after the receive count is at or above the receive threshold.
- R5: Status bit 4 is set one cycle after the transmit count is at or below the transmit threshold. After reset the transmit threshold is DEPTH/4, so bit 4 is set one cycle after reset.
- R6: An engine push into a full receive queue sets status bit 8. The byte is dropped and the count stays at DEPTH.
- R7: A pulse on `xfer_done` sets status bit 12 in the following cycle.
- R8: Writing 1 to a status bit clears it, and status bits stay set until cleared. If the bit's set condition is true in the cycle of the clear, the bit stays set.
- R9: `irq` is 1 exactly when some status bit and its enable bit are both 1. The enable word is 0 after reset.
- R10: Writing 1 to control bit 15 flushes the receive queue, and writing 1 to bit 31 flushes the transmit queue. The bit reads 1 for one cycle, then 0, and the count is then 0. A write that carries a flush bit leaves both thresholds unchanged.
- R11: The receive threshold is in control bits 7:0 and the transmit threshold in bits 23:16. After reset they are 3*DEPTH/4 and DEPTH/4.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| reg_we | input | 1 | Register write strobe |
| reg_addr | input | 2 | Register word address |
| reg_wdata | input | 32 | Register write data |
| reg_rdata | output | 32 | Register read data (combinational) |
| tx_wr_en | input | 1 | Host write into transmit queue |
| tx_wr_data | input | 8 | Host byte to transmit |
| rx_rd_en | input | 1 | Host pop from receive queue |
| rx_rd_data | output | 8 | Oldest received byte |
| eng_tx_pop | input | 1 | Engine takes a transmit byte |
| eng_tx_data | output | 8 | Oldest transmit byte |
| eng_tx_empty | output | 1 | Transmit queue empty |
| eng_rx_push | input | 1 | Engine delivers a received byte |
| eng_rx_data | input | 8 | Received byte |
| xfer_done | input | 1 | Transfer-complete pulse |
| irq | output | 1 | Masked interrupt |

## Verification
On every cycle, the assertions check the following:
- A threshold condition is followed by its status bit.
- An overflow push is followed by bit 8 and leaves the count unchanged.
- A completion pulse is followed by bit 12.
- A clear without a set condition empties the bit, and set bits stay set otherwise.
- A flush state is followed by an empty queue, with the thresholds held.

Only the bench scenarios show byte ordering through both queues, the exact field positions in the register words, and the one-cycle readback of a flush bit. They also cover a sweep of threshold values against every fill level and all sixteen enable masks.

// File: rtl/sfi_pkg.sv
package sfi_pkg;

    localparam int NSRC = 4;

    localparam logic [1:0] ADDR_IEN  = 2'd0;
    localparam logic [1:0] ADDR_ISTA = 2'd1;
    localparam logic [1:0] ADDR_FCTL = 2'd2;
    localparam logic [1:0] ADDR_FLVL = 2'd3;

    localparam int SRC_RDY  = 0;
    localparam int SRC_TREQ = 1;
    localparam int SRC_OVF  = 2;
    localparam int SRC_DONE = 3;

    localparam int RX_FLUSH_BIT = 15;
    localparam int TX_FLUSH_BIT = 31;
    localparam int TX_TRIG_LSB  = 16;

    typedef enum logic {
        FL_IDLE,
        FL_FLUSH
    } flush_state_e;

    function automatic logic [31:0] spread_src(input logic [NSRC-1:0] v);
        logic [31:0] w;
        w = '0;
        for (int i = 0; i < NSRC; i++) w[i*4] = v[i];
        return w;
    endfunction

    function automatic logic [NSRC-1:0] gather_src(input logic [31:0] w);
        logic [NSRC-1:0] v;
        for (int i = 0; i < NSRC; i++) v[i] = w[i*4];
        return v;
    endfunction

endpackage

// File: rtl/sfi_flush_fsm.sv
module sfi_flush_fsm
    import sfi_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic req,
    output logic busy
);

    flush_state_e state_q, state_d;

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            FL_IDLE:  if (req) state_d = FL_FLUSH;
            FL_FLUSH: state_d = FL_IDLE;
            default:  state_d = FL_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= FL_IDLE;
        else        state_q <= state_d;
    end

    always_comb begin
        busy = (state_q == FL_FLUSH);
    end

    // R10: a flush request from idle enters the flush state
    p_flush_enter_r10: assert property (@(posedge clk) disable iff (!rst_n)
        (req && state_q == FL_IDLE) |=> busy);

    // R10: the flush bit self-clears after one cycle
    p_flush_self_clear_r10: assert property (@(posedge clk) disable iff (!rst_n)
        busy |=> !busy);

endmodule

// File: rtl/sfi_byte_fifo.sv
module sfi_byte_fifo #(
    parameter int DEPTH = 64
) (
    input  logic                         clk,
    input  logic                         rst_n,
    input  logic                         clear,
    input  logic                         push,
    input  logic [7:0]                   push_data,
    input  logic                         pop,
    output logic [7:0]                   pop_data,
    output logic [$clog2(DEPTH+1)-1:0]   count,
    output logic                         full,
    output logic                         empty
);

    localparam int AW = $clog2(DEPTH);
    localparam int CW = $clog2(DEPTH+1);

    logic [7:0]    mem [DEPTH];
    logic [AW-1:0] wr_ptr, rd_ptr;
    logic          do_push, do_pop;

    initial assert (DEPTH == 64 || DEPTH == 128);

    always_comb begin
        full     = (count == CW'(DEPTH));
        empty    = (count == '0);
        do_push  = push && !full && !clear;
        do_pop   = pop && !empty && !clear;
        pop_data = mem[rd_ptr];
    end

    always_ff @(posedge clk) begin
        if (do_push) mem[wr_ptr] <= push_data;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            wr_ptr <= '0;
            rd_ptr <= '0;
            count  <= '0;
        end else if (clear) begin
            wr_ptr <= '0;
            rd_ptr <= '0;
            count  <= '0;
        end else begin
            if (do_push) wr_ptr <= wr_ptr + 1'b1;
            if (do_pop)  rd_ptr <= rd_ptr + 1'b1;
            if (do_push && !do_pop)      count <= count + 1'b1;
            else if (do_pop && !do_push) count <= count - 1'b1;
        end
    end

    // R2: the count never exceeds the depth
    p_count_bound_r2: assert property (@(posedge clk) disable iff (!rst_n)
        count <= CW'(DEPTH));

    // R6: a push into a full queue without a pop leaves the count alone
    p_full_drop_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (push && full && !pop && !clear) |=> $stable(count));

    // R3: a pop on an empty queue without a push keeps it empty
    p_empty_pop_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (pop && empty && !push) |=> empty);

endmodule

// File: rtl/sfi_irq_regs.sv
module sfi_irq_regs
    import sfi_pkg::*;
(
    input  logic            clk,
    input  logic            rst_n,
    input  logic [NSRC-1:0] set_i,
    input  logic [NSRC-1:0] clr_i,
    input  logic            en_we,
    input  logic [NSRC-1:0] en_wdata,
    output logic [NSRC-1:0] stat_o,
    output logic [NSRC-1:0] en_o,
    output logic            irq_o
);

    for (genvar g = 0; g < NSRC; g++) begin : g_src
        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n)         stat_o[g] <= 1'b0;
            else if (set_i[g])  stat_o[g] <= 1'b1;
            else if (clr_i[g])  stat_o[g] <= 1'b0;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)     en_o <= '0;
        else if (en_we) en_o <= en_wdata;
    end

    always_comb irq_o = |(stat_o & en_o);

    // R8: a clear with no concurrent set empties the bit
    p_clear_r8: assert property (@(posedge clk) disable iff (!rst_n)
        ((clr_i & ~set_i) != '0) |=> ((stat_o & $past(clr_i & ~set_i)) == '0));

    // R8: set bits that are not cleared stay set
    p_sticky_r8: assert property (@(posedge clk) disable iff (!rst_n)
        1'b1 |=> ((stat_o & $past(stat_o & ~clr_i)) == $past(stat_o & ~clr_i)));

    // R8: a set in the cycle of a clear wins
    p_set_wins_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (set_i != '0) |=> ((stat_o & $past(set_i)) == $past(set_i)));

endmodule

// File: rtl/spi_fifo_irq.sv
module spi_fifo_irq
    import sfi_pkg::*;
#(
    parameter int DEPTH = 64
) (
    input  logic        clk,
    input  logic        rst_n,
    input  logic        reg_we,
    input  logic [1:0]  reg_addr,
    input  logic [31:0] reg_wdata,
    output logic [31:0] reg_rdata,
    input  logic        tx_wr_en,
    input  logic [7:0]  tx_wr_data,
    input  logic        rx_rd_en,
    output logic [7:0]  rx_rd_data,
    input  logic        eng_tx_pop,
    output logic [7:0]  eng_tx_data,
    output logic        eng_tx_empty,
    input  logic        eng_rx_push,
    input  logic [7:0]  eng_rx_data,
    input  logic        xfer_done,
    output logic        irq
);

    localparam int CW = $clog2(DEPTH+1);
    localparam int KW = 9;
    localparam logic [7:0] RX_TRIG_RST = 8'(DEPTH * 3 / 4);
    localparam logic [7:0] TX_TRIG_RST = 8'(DEPTH / 4);

    logic [CW-1:0]   rx_count, tx_count;
    logic            rx_full, rx_empty, tx_full, tx_empty;
    logic            rx_busy, tx_busy;
    logic [7:0]      rx_trig_q, tx_trig_q;
    logic            wr_ien, wr_ista, wr_fctl;
    logic            rx_flush_req, tx_flush_req;
    logic [NSRC-1:0] src_set, src_clr, stat, en;
    logic            unused_wdata;

    always_comb begin
        wr_ien       = reg_we && (reg_addr == ADDR_IEN);
        wr_ista      = reg_we && (reg_addr == ADDR_ISTA);
        wr_fctl      = reg_we && (reg_addr == ADDR_FCTL);
        rx_flush_req = wr_fctl && reg_wdata[RX_FLUSH_BIT];
        tx_flush_req = wr_fctl && reg_wdata[TX_FLUSH_BIT];
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            rx_trig_q <= RX_TRIG_RST;
            tx_trig_q <= TX_TRIG_RST;
        end else if (wr_fctl && !rx_flush_req && !tx_flush_req) begin
            rx_trig_q <= reg_wdata[7:0];
            tx_trig_q <= reg_wdata[TX_TRIG_LSB +: 8];
        end
    end

    sfi_flush_fsm u_rx_flush (
        .clk  (clk),
        .rst_n(rst_n),
        .req  (rx_flush_req),
        .busy (rx_busy)
    );

    sfi_flush_fsm u_tx_flush (
        .clk  (clk),
        .rst_n(rst_n),
        .req  (tx_flush_req),
        .busy (tx_busy)
    );

    sfi_byte_fifo #(.DEPTH(DEPTH)) u_txq (
        .clk      (clk),
        .rst_n    (rst_n),
        .clear    (tx_busy),
        .push     (tx_wr_en),
        .push_data(tx_wr_data),
        .pop      (eng_tx_pop),
        .pop_data (eng_tx_data),
        .count    (tx_count),
        .full     (tx_full),
        .empty    (tx_empty)
    );

    sfi_byte_fifo #(.DEPTH(DEPTH)) u_rxq (
        .clk      (clk),
        .rst_n    (rst_n),
        .clear    (rx_busy),
        .push     (eng_rx_push),
        .push_data(eng_rx_data),
        .pop      (rx_rd_en),
        .pop_data (rx_rd_data),
        .count    (rx_count),
        .full     (rx_full),
        .empty    (rx_empty)
    );

    always_comb begin
        src_set           = '0;
        src_set[SRC_RDY]  = KW'(rx_count) >= KW'(rx_trig_q);
        src_set[SRC_TREQ] = KW'(tx_count) <= KW'(tx_trig_q);
        src_set[SRC_OVF]  = eng_rx_push && rx_full && !rx_busy;
        src_set[SRC_DONE] = xfer_done;
        src_clr           = wr_ista ? gather_src(reg_wdata) : '0;
        eng_tx_empty      = tx_empty;
    end

    sfi_irq_regs u_irq (
        .clk     (clk),
        .rst_n   (rst_n),
        .set_i   (src_set),
        .clr_i   (src_clr),
        .en_we   (wr_ien),
        .en_wdata(gather_src(reg_wdata)),
        .stat_o  (stat),
        .en_o    (en),
        .irq_o   (irq)
    );

    always_comb begin
        unique case (reg_addr)
            ADDR_IEN:  reg_rdata = spread_src(en);
            ADDR_ISTA: reg_rdata = spread_src(stat);
            ADDR_FCTL: reg_rdata = {tx_busy, 7'b0, tx_trig_q, rx_busy, 7'b0, rx_trig_q};
            ADDR_FLVL: reg_rdata = (32'(tx_count) << TX_TRIG_LSB) | 32'(rx_count);
            default:   reg_rdata = '0;
        endcase
    end

    assign unused_wdata = ^{reg_wdata[30:24], reg_wdata[14:8], rx_empty, tx_full};

    // R4: receive threshold reached is followed by bit 0
    p_rx_ready_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (KW'(rx_count) >= KW'(rx_trig_q)) |=> stat[SRC_RDY]);

    // R5: transmit threshold reached is followed by bit 4
    p_tx_req_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (KW'(tx_count) <= KW'(tx_trig_q)) |=> stat[SRC_TREQ]);

    // R6: a push into a full receive queue flags overflow
    p_overflow_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (eng_rx_push && rx_full && !rx_busy) |=> stat[SRC_OVF]);

    // R7: completion pulse sets bit 12
    p_done_r7: assert property (@(posedge clk) disable iff (!rst_n)
        xfer_done |=> stat[SRC_DONE]);

    // R10: a flush leaves the queue empty
    p_rx_flush_r10: assert property (@(posedge clk) disable iff (!rst_n)
        rx_busy |=> (rx_count == '0));
    p_tx_flush_r10: assert property (@(posedge clk) disable iff (!rst_n)
        tx_busy |=> (tx_count == '0));

    // R10: a write carrying a flush bit keeps both thresholds
    p_trig_keep_r10: assert property (@(posedge clk) disable iff (!rst_n)
        (rx_flush_req || tx_flush_req) |=> ($stable(rx_trig_q) && $stable(tx_trig_q)));

endmodule

// File: tb/sim_spi_fifo_irq.sv
module sim_spi_fifo_irq;

    localparam int DEPTH = 64;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        reg_we = 1'b0;
    logic [1:0]  reg_addr = 2'd0;
    logic [31:0] reg_wdata = '0;
    logic [31:0] reg_rdata;
    logic        tx_wr_en = 1'b0;
    logic [7:0]  tx_wr_data = '0;
    logic        rx_rd_en = 1'b0;
    logic [7:0]  rx_rd_data;
    logic        eng_tx_pop = 1'b0;
    logic [7:0]  eng_tx_data;
    logic        eng_tx_empty;
    logic        eng_rx_push = 1'b0;
    logic [7:0]  eng_rx_data = '0;
    logic        xfer_done = 1'b0;
    logic        irq;

    int tests = 0;
    int fails = 0;
    bit finished = 0;

    always #4 clk = ~clk;

    spi_fifo_irq #(.DEPTH(DEPTH)) u0 (.*);

    task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
        tests++;
        if (!ok) begin
            fails++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic wr(input logic [1:0] a, input logic [31:0] d);
        @(negedge clk);
        reg_we = 1'b1; reg_addr = a; reg_wdata = d;
        @(negedge clk);
        reg_we = 1'b0;
    endtask

    task automatic rd(input logic [1:0] a, output logic [31:0] d);
        reg_addr = a;
        #1;
        d = reg_rdata;
    endtask

    task automatic txw(input logic [7:0] b);
        @(negedge clk);
        tx_wr_en = 1'b1; tx_wr_data = b;
        @(negedge clk);
        tx_wr_en = 1'b0;
    endtask

    task automatic rxp(input logic [7:0] b);
        @(negedge clk);
        eng_rx_push = 1'b1; eng_rx_data = b;
        @(negedge clk);
        eng_rx_push = 1'b0;
    endtask

    task automatic pulse(ref logic s);
        @(negedge clk);
        s = 1'b1;
        @(negedge clk);
        s = 1'b0;
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!finished) begin
            tests++; fails++;
            $display("FAIL watchdog actual=0 expected=1");
            $display("[TB] %0d tests run, %0d failed", tests, fails);
            $finish;
        end
    end

    initial begin
        logic [31:0] v;
        int tl [3] = '{1, 32, 64};

        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        @(negedge clk);
        rd(2'd3, v); chk(v == 32'h0, "R1 levels after reset", v, 32'h0);
        rd(2'd2, v); chk(v == 32'h0010_0030, "R11 reset thresholds", v, 32'h0010_0030);
        rd(2'd1, v); chk(v == 32'h10, "R5 tx request after reset", v, 32'h10);
        chk(irq == 1'b0, "R9 irq masked after reset", 32'(irq), 0);

        wr(2'd0, 32'h1111);
        chk(irq == 1'b1, "R9 irq with all enabled", 32'(irq), 1);
        wr(2'd1, 32'h10);
        rd(2'd1, v); chk(v[4] == 1'b1, "R8 persisting source reasserts", 32'(v[4]), 1);

        wr(2'd2, 32'h0000_0040);
        rd(2'd2, v); chk(v == 32'h40, "R11 threshold fields", v, 32'h40);

        // R2 fill the transmit queue
        for (int i = 0; i < DEPTH; i++) begin
            txw(8'((i * 7 + 3) & 255));
            rd(2'd3, v);
            chk(v[23:16] == 8'(i + 1), "R2 tx count", 32'(v[23:16]), i + 1);
            if (i == 0) begin
                wr(2'd1, 32'h10);
                rd(2'd1, v); chk(v[4] == 1'b0, "R8 clear without set", 32'(v[4]), 0);
            end
        end
        txw(8'hEE);
        rd(2'd3, v); chk(v[23:16] == 8'(DEPTH), "R2 write to full dropped", 32'(v[23:16]), DEPTH);
        for (int i = 0; i < DEPTH; i++) begin
            @(negedge clk);
            chk(eng_tx_data == 8'((i * 7 + 3) & 255), "R2 tx order", 32'(eng_tx_data), (i * 7 + 3) & 255);
            eng_tx_pop = 1'b1;
            @(negedge clk);
            eng_tx_pop = 1'b0;
        end
        chk(eng_tx_empty == 1'b1, "R2 tx empty after drain", 32'(eng_tx_empty), 1);
        @(negedge clk);
        rd(2'd1, v); chk(v[4] == 1'b1, "R5 tx request at threshold 0", 32'(v[4]), 1);

        // R4 threshold sweep over every fill level
        foreach (tl[k]) begin
            wr(2'd2, 32'(tl[k]));
            wr(2'd2, 32'h0000_8000);
            @(negedge clk);
            wr(2'd1, 32'h1);
            rd(2'd1, v); chk(v[0] == 1'b0, "R4 ready cleared below threshold", 32'(v[0]), 0);
            for (int n = 1; n <= DEPTH; n++) begin
                rxp(8'((n * 13) & 255));
                @(negedge clk);
                rd(2'd3, v); chk(v[7:0] == 8'(n), "R3 rx count", 32'(v[7:0]), n);
                rd(2'd1, v); chk(v[0] == (n >= tl[k]), "R4 ready vs threshold", 32'(v[0]), 32'(n >= tl[k]));
            end
        end
        rxp(8'hAA);
        rd(2'd1, v); chk(v[8] == 1'b1, "R6 overflow flag", 32'(v[8]), 1);
        rd(2'd3, v); chk(v[7:0] == 8'(DEPTH), "R6 count held at depth", 32'(v[7:0]), DEPTH);
        for (int i = 1; i <= DEPTH; i++) begin
            chk(rx_rd_data == 8'((i * 13) & 255), "R3 rx order", 32'(rx_rd_data), (i * 13) & 255);
            pulse(rx_rd_en);
        end
        pulse(rx_rd_en);
        rd(2'd3, v); chk(v[7:0] == 8'h0, "R3 pop on empty", 32'(v[7:0]), 0);

        // R10 flush both queues
        for (int i = 0; i < 5; i++) rxp(8'(i));
        for (int i = 0; i < 3; i++) txw(8'(i));
        wr(2'd2, 32'h8000_8000);
        rd(2'd2, v); chk(v == 32'h8000_8040, "R10 flush bits read 1", v, 32'h8000_8040);
        rd(2'd3, v); chk(v == 32'h0003_0005, "R10 levels before flush completes", v, 32'h0003_0005);
        @(negedge clk);
        rd(2'd2, v); chk(v == 32'h0000_0040, "R10 self clear, thresholds kept", v, 32'h40);
        rd(2'd3, v); chk(v == 32'h0, "R10 queues empty", v, 32'h0);

        pulse(xfer_done);
        rd(2'd1, v); chk(v[12] == 1'b1, "R7 transfer complete", 32'(v[12]), 1);

        wr(2'd1, 32'h0101);
        rd(2'd1, v); chk(v == 32'h1010, "R8 clear ready and overflow", v, 32'h1010);

        // R9 all enable masks
        for (int m = 0; m < 16; m++) begin
            wr(2'd0, (32'(m & 1)) | (32'((m >> 1) & 1) << 4) | (32'((m >> 2) & 1) << 8) | (32'((m >> 3) & 1) << 12));
            chk(irq == (((m >> 1) & 1) | ((m >> 3) & 1)) != 0, "R9 masked irq", 32'(irq),
                32'((((m >> 1) & 1) | ((m >> 3) & 1)) != 0));
        end

        finished = 1;
        $display("[TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end

endmodule